// File: doc/BRIEF.md
# NOR Flash Program and Erase Sequencer

This block sits on the host side of an asynchronous parallel NOR flash bus that is shared by two dies, each with its own chip enable. It takes one request at a time, either to write one word or to erase one sector. It then plays out the unlock and command writes the flash expects. Each write strobe is shaped from a clock count that the block derives from nanosecond parameters and the clock period. Once the last command write is done, it reads status from the target location again and again until the embedded operation reports completion.

Completion is judged from the data-polling bit, DQ7. While the flash is busy, DQ7 reads back as the complement of the bit being written. When the operation is over, it reads back the true bit: bit 7 of the data for a word write, and 1 for an erase. If the exceeded-time flag, DQ5, is seen high while DQ7 still mismatches, the block reads once more. A second mismatch ends the request with an error, after a reset command has been written to the flash.

Requests arrive on a valid/ready pair. Ready is high only while the block is idle, and the request is taken on a clock edge where valid and ready are both high. While a request is in flight, ready stays low and the request inputs are not looked at. The result comes back as a one-cycle done pulse with an error flag beside it. There is no back-pressure on the result, so the requester must catch the pulse.

Top module: `nor_flash_ctrl`

## Requirements
- R1: A word-write request produces exactly four flash writes, as (address, data): (555h, AAh), (2AAh, 55h), (555h, A0h), (request address, request data).
- R2: A sector-erase request produces exactly six flash writes: (555h, AAh), (2AAh, 55h), (555h, 80h), (555h, AAh), (2AAh, 55h), (request address, 30h).
- R3: Each write holds the write strobe low for ceil(T_WP_NS/CLK_NS) cycles, which is 3 cycles at defaults. Address and data stay unchanged while the strobe is low. Chip enable stays low for at least ceil(T_WC_NS/CLK_NS) cycles around each write.
- R4: No more than one chip enable is low at any time, and it is the one picked by `req_die`. Output enable and write strobe are never both low. The data bus is driven whenever the write strobe is low.
- R5: A status read holds output enable low for max(ceil(T_RC_NS/CLK_NS)-1, ceil(T_OE_NS/CLK_NS)) cycles, which is 4 at defaults, and samples the bus in the last of them. The bus is not driven while output enable is low. Output enable then stays high for at least ceil(T_DF_NS/CLK_NS) cycles before the next strobe.
- R6: Once the command writes are done, status reads at the request address continue until bit 7 equals bit 7 of the request data for a word write, or equals 1 for an erase. Done then pulses with the error flag low.
- R7: A status read whose bit 7 mismatches while bit 5 is low is followed by another status read, with no limit on their number.
- R8: A mismatching read with bit 5 high is followed by exactly one more read. If that read matches, the request finishes without error.
- R9: If that extra read also mismatches, the block writes F0h to the request address, then pulses done with the error flag high. No further status read takes place.
- R10: Ready is low from the acceptance edge until after the done pulse. Request inputs presented while ready is low start nothing. Done lasts exactly one cycle, and ready is high in the cycle after it.
- R11: During reset, all chip enables, the write strobe and output enable are high, the bus is not driven, done is low and ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request will be taken |
| req_erase | input | 1 | 1 = sector erase, 0 = word write |
| req_die | input | DIE_W | Die to address |
| req_addr | input | AW | Word address or sector address |
| req_data | input | DW | Word to write (ignored for erase) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Error flag, meaningful while done is high |
| fl_ce_n | output | NDIE | Active-low chip enable per die |
| fl_we_n | output | 1 | Active-low write strobe |
| fl_oe_n | output | 1 | Active-low output enable |
| fl_addr | output | AW | Flash address bus |
| fl_dq_out | output | DW | Data driven toward the flash |
| fl_dq_oe | output | 1 | High while the block drives the data bus |
| fl_dq_in | input | DW | Data read back from the flash |

## Verification
The bench builds the block with its defaults: a 20 ns clock, a 19-bit address, 16-bit data and two dies. With these values the derived strobe widths are 3 cycles for the write strobe, 4 for output enable and 2 for the bus float. Both the minimum-width rule and the total-cycle rule therefore apply, and both widths can be checked exactly at the pins. A behavioural flash model in the bench feeds back a scripted series of busy reads, some with the timeout flag set. This reaches every polling outcome: an immediate match, long busy runs, a recovered re-read, and both failure paths on each die. A done word with bit 5 set is also used, to show that the timeout flag is ignored once DQ7 matches.

// File: rtl/nor_ctrl_pkg.sv
package nor_ctrl_pkg;

  typedef enum logic [2:0] {
    BP_IDLE, BP_WSETUP, BP_WLOW, BP_WHIGH, BP_RSETUP, BP_RLOW, BP_FLOAT
  } bus_phase_e;

  typedef enum logic [3:0] {
    CS_IDLE, CS_CMD_GO, CS_CMD_WAIT, CS_POLL_GO, CS_POLL_WAIT,
    CS_ABORT_GO, CS_ABORT_WAIT, CS_FIN
  } ctl_state_e;

  typedef enum logic [1:0] {
    VD_PASS, VD_AGAIN, VD_RETRY, VD_FAIL
  } verdict_e;

  // nanoseconds to whole clock cycles, rounded up, never below one
  function automatic int ns_to_cyc(input int ns, input int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int cyc_max(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/nor_cmd_table.sv
module nor_cmd_table #(
  parameter int AW = 19,
  parameter int DW = 16
) (
  input  logic          erase,
  input  logic          abort,
  input  logic [2:0]    step,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data,
  output logic          cmd_last
);
  localparam logic [AW-1:0] UNLOCK_A = AW'(12'h555);
  localparam logic [AW-1:0] UNLOCK_B = AW'(12'h2AA);
  localparam logic [DW-1:0] KEY_A    = DW'(8'hAA);
  localparam logic [DW-1:0] KEY_B    = DW'(8'h55);
  localparam logic [DW-1:0] OP_WORD  = DW'(8'hA0);
  localparam logic [DW-1:0] OP_SETUP = DW'(8'h80);
  localparam logic [DW-1:0] OP_SECT  = DW'(8'h30);
  localparam logic [DW-1:0] OP_RESET = DW'(8'hF0);

  always_comb begin
    cmd_addr = UNLOCK_A;
    cmd_data = KEY_A;
    cmd_last = 1'b0;
    if (abort) begin
      cmd_addr = tgt_addr;
      cmd_data = OP_RESET;
      cmd_last = 1'b1;
    end else if (!erase) begin
      case (step)
        3'd0: begin cmd_addr = UNLOCK_A; cmd_data = KEY_A; end
        3'd1: begin cmd_addr = UNLOCK_B; cmd_data = KEY_B; end
        3'd2: begin cmd_addr = UNLOCK_A; cmd_data = OP_WORD; end
        default: begin cmd_addr = tgt_addr; cmd_data = tgt_data; cmd_last = 1'b1; end
      endcase
    end else begin
      case (step)
        3'd0: begin cmd_addr = UNLOCK_A; cmd_data = KEY_A; end
        3'd1: begin cmd_addr = UNLOCK_B; cmd_data = KEY_B; end
        3'd2: begin cmd_addr = UNLOCK_A; cmd_data = OP_SETUP; end
        3'd3: begin cmd_addr = UNLOCK_A; cmd_data = KEY_A; end
        3'd4: begin cmd_addr = UNLOCK_B; cmd_data = KEY_B; end
        default: begin cmd_addr = tgt_addr; cmd_data = OP_SECT; cmd_last = 1'b1; end
      endcase
    end
  end
endmodule

// File: rtl/nor_bus_cycle.sv
module nor_bus_cycle
  import nor_ctrl_pkg::*;
#(
  parameter int AW     = 19,
  parameter int DW     = 16,
  parameter int WP_CYC = 3,
  parameter int WH_CYC = 2,
  parameter int RD_CYC = 4,
  parameter int DF_CYC = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic          is_read,
  input  logic [AW-1:0] addr_in,
  input  logic [DW-1:0] wdata_in,
  input  logic [DW-1:0] dq_in,
  output logic          cyc_done,
  output logic          ce_act,
  output logic          we_n,
  output logic          oe_n,
  output logic          dq_oe,
  output logic [AW-1:0] addr_out,
  output logic [DW-1:0] dq_out,
  output logic [DW-1:0] rdata
);
  localparam int MAXC = cyc_max(cyc_max(WP_CYC, WH_CYC), cyc_max(RD_CYC, DF_CYC));
  localparam int CW   = $clog2(MAXC + 1);

  bus_phase_e    phase;
  logic [CW-1:0] cnt;
  logic          cnt_zero;

  assign cnt_zero = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase    <= BP_IDLE;
      cnt      <= '0;
      addr_out <= '0;
      dq_out   <= '0;
      rdata    <= '0;
    end else begin
      case (phase)
        BP_IDLE: if (start) begin
          addr_out <= addr_in;
          dq_out   <= wdata_in;
          phase    <= is_read ? BP_RSETUP : BP_WSETUP;
        end
        BP_WSETUP: begin
          phase <= BP_WLOW;
          cnt   <= CW'(WP_CYC - 1);
        end
        BP_WLOW: if (cnt_zero) begin
          phase <= BP_WHIGH;
          cnt   <= CW'(WH_CYC - 1);
        end else cnt <= cnt - 1'b1;
        BP_WHIGH: if (cnt_zero) phase <= BP_IDLE;
                  else cnt <= cnt - 1'b1;
        BP_RSETUP: begin
          phase <= BP_RLOW;
          cnt   <= CW'(RD_CYC - 1);
        end
        BP_RLOW: if (cnt_zero) begin
          rdata <= dq_in;
          phase <= BP_FLOAT;
          cnt   <= CW'(DF_CYC - 1);
        end else cnt <= cnt - 1'b1;
        BP_FLOAT: if (cnt_zero) phase <= BP_IDLE;
                  else cnt <= cnt - 1'b1;
        default: phase <= BP_IDLE;
      endcase
    end
  end

  assign cyc_done = cnt_zero && (phase == BP_WHIGH || phase == BP_FLOAT);
  assign ce_act   = (phase != BP_IDLE) && (phase != BP_FLOAT);
  assign we_n     = (phase != BP_WLOW);
  assign oe_n     = (phase != BP_RLOW);
  assign dq_oe    = (phase == BP_WSETUP) || (phase == BP_WLOW) || (phase == BP_WHIGH);
endmodule

// File: rtl/nor_status_judge.sv
module nor_status_judge
  import nor_ctrl_pkg::*;
#(
  parameter int DW        = 16,
  parameter int POLL_BIT  = 7,
  parameter int LIMIT_BIT = 5
) (
  input  logic [DW-1:0] status,
  input  logic [DW-1:0] expect_word,
  input  logic          retried,
  output verdict_e      verdict
);
  localparam logic [DW-1:0] POLL_MASK  = DW'(1) << POLL_BIT;
  localparam logic [DW-1:0] LIMIT_MASK = DW'(1) << LIMIT_BIT;

  logic mismatch, limit_hit;
  assign mismatch  = |((status ^ expect_word) & POLL_MASK);
  assign limit_hit = |(status & LIMIT_MASK);

  always_comb begin
    if (!mismatch)     verdict = VD_PASS;
    else if (retried)  verdict = VD_FAIL;
    else if (limit_hit) verdict = VD_RETRY;
    else               verdict = VD_AGAIN;
  end
endmodule

// File: rtl/nor_flash_ctrl.sv
module nor_flash_ctrl
  import nor_ctrl_pkg::*;
#(
  parameter int NDIE      = 2,
  parameter int AW        = 19,
  parameter int DW        = 16,
  parameter int CLK_NS    = 20,
  parameter int T_WP_NS   = 50,
  parameter int T_WPH_NS  = 30,
  parameter int T_WC_NS   = 100,
  parameter int T_RC_NS   = 100,
  parameter int T_OE_NS   = 40,
  parameter int T_DF_NS   = 30,
  parameter int POLL_BIT  = 7,
  parameter int LIMIT_BIT = 5,
  localparam int DIE_W    = (NDIE > 1) ? $clog2(NDIE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_erase,
  input  logic [DIE_W-1:0] req_die,
  input  logic [AW-1:0]    req_addr,
  input  logic [DW-1:0]    req_data,
  output logic             done,
  output logic             err,
  output logic [NDIE-1:0]  fl_ce_n,
  output logic             fl_we_n,
  output logic             fl_oe_n,
  output logic [AW-1:0]    fl_addr,
  output logic [DW-1:0]    fl_dq_out,
  output logic             fl_dq_oe,
  input  logic [DW-1:0]    fl_dq_in
);
  localparam int WP_CYC = ns_to_cyc(T_WP_NS, CLK_NS);
  localparam int WH_CYC = cyc_max(ns_to_cyc(T_WPH_NS, CLK_NS),
                                  ns_to_cyc(T_WC_NS, CLK_NS) - 1 - WP_CYC);
  localparam int RD_CYC = cyc_max(ns_to_cyc(T_RC_NS, CLK_NS) - 1,
                                  ns_to_cyc(T_OE_NS, CLK_NS));
  localparam int DF_CYC = ns_to_cyc(T_DF_NS, CLK_NS);

  ctl_state_e       state;
  logic             erase_q, retried_q, err_q;
  logic [DIE_W-1:0] die_q;
  logic [AW-1:0]    addr_q;
  logic [DW-1:0]    data_q;
  logic [2:0]       step_q;

  logic             bus_start, bus_read, bus_done, bus_ce;
  logic [AW-1:0]    cmd_addr, bus_addr;
  logic [DW-1:0]    cmd_data, bus_rdata, expect_word;
  logic             cmd_last, abort_sel;
  verdict_e         verdict;

  assign abort_sel = (state == CS_ABORT_GO);
  assign bus_start = (state == CS_CMD_GO) || (state == CS_POLL_GO) || abort_sel;
  assign bus_read  = (state == CS_POLL_GO);
  assign bus_addr  = bus_read ? addr_q : cmd_addr;
  assign expect_word = erase_q ? '1 : data_q;

  nor_cmd_table #(.AW(AW), .DW(DW)) u_table (
    .erase(erase_q), .abort(abort_sel), .step(step_q),
    .tgt_addr(addr_q), .tgt_data(data_q),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cmd_last(cmd_last)
  );

  nor_bus_cycle #(
    .AW(AW), .DW(DW), .WP_CYC(WP_CYC), .WH_CYC(WH_CYC),
    .RD_CYC(RD_CYC), .DF_CYC(DF_CYC)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .start(bus_start), .is_read(bus_read),
    .addr_in(bus_addr), .wdata_in(cmd_data), .dq_in(fl_dq_in),
    .cyc_done(bus_done), .ce_act(bus_ce), .we_n(fl_we_n), .oe_n(fl_oe_n),
    .dq_oe(fl_dq_oe), .addr_out(fl_addr), .dq_out(fl_dq_out), .rdata(bus_rdata)
  );

  nor_status_judge #(.DW(DW), .POLL_BIT(POLL_BIT), .LIMIT_BIT(LIMIT_BIT)) u_judge (
    .status(bus_rdata), .expect_word(expect_word), .retried(retried_q),
    .verdict(verdict)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= CS_IDLE;
      erase_q   <= 1'b0;
      retried_q <= 1'b0;
      err_q     <= 1'b0;
      die_q     <= '0;
      addr_q    <= '0;
      data_q    <= '0;
      step_q    <= '0;
    end else begin
      case (state)
        CS_IDLE: if (req_valid) begin
          erase_q   <= req_erase;
          die_q     <= req_die;
          addr_q    <= req_addr;
          data_q    <= req_data;
          step_q    <= '0;
          retried_q <= 1'b0;
          err_q     <= 1'b0;
          state     <= CS_CMD_GO;
        end
        CS_CMD_GO:   state <= CS_CMD_WAIT;
        CS_CMD_WAIT: if (bus_done) begin
          if (cmd_last) state <= CS_POLL_GO;
          else begin
            step_q <= step_q + 3'd1;
            state  <= CS_CMD_GO;
          end
        end
        CS_POLL_GO:   state <= CS_POLL_WAIT;
        CS_POLL_WAIT: if (bus_done) begin
          case (verdict)
            VD_PASS:  state <= CS_FIN;
            VD_AGAIN: state <= CS_POLL_GO;
            VD_RETRY: begin retried_q <= 1'b1; state <= CS_POLL_GO; end
            default:  begin err_q <= 1'b1; state <= CS_ABORT_GO; end
          endcase
        end
        CS_ABORT_GO:   state <= CS_ABORT_WAIT;
        CS_ABORT_WAIT: if (bus_done) state <= CS_FIN;
        CS_FIN:        state <= CS_IDLE;
        default:       state <= CS_IDLE;
      endcase
    end
  end

  assign req_ready = (state == CS_IDLE);
  assign done      = (state == CS_FIN);
  assign err       = (state == CS_FIN) && err_q;

  for (genvar d = 0; d < NDIE; d++) begin : g_ce
    assign fl_ce_n[d] = !(bus_ce && (die_q == DIE_W'(d)));
  end
endmodule

// File: rtl/nor_flash_ctrl_chk.sv
module nor_flash_ctrl_chk
  import nor_ctrl_pkg::*;
#(
  parameter int NDIE    = 2,
  parameter int AW      = 19,
  parameter int DW      = 16,
  parameter int CLK_NS  = 20,
  parameter int T_WP_NS = 50
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            done,
  input logic [NDIE-1:0] fl_ce_n,
  input logic            fl_we_n,
  input logic            fl_oe_n,
  input logic [AW-1:0]   fl_addr,
  input logic [DW-1:0]   fl_dq_out,
  input logic            fl_dq_oe
);
  localparam int WP_MIN = ns_to_cyc(T_WP_NS, CLK_NS);

  logic [7:0] low_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) low_cnt <= '0;
    else if (!fl_we_n) low_cnt <= (low_cnt == 8'hFF) ? low_cnt : low_cnt + 8'd1;
    else low_cnt <= '0;
  end

  AST_ONE_DIE: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(~fl_ce_n) <= 1); // R4
  AST_NO_DUAL_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n)); // R4
  AST_DRIVE_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> fl_dq_oe); // R4
  AST_FLOAT_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe); // R5
  AST_HOLD_IN_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dq_out))); // R3
  AST_WE_WIDTH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fl_we_n) |-> (low_cnt >= 8'(WP_MIN))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_TO_READY: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> req_ready); // R10
  AST_IDLE_BUS_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (&fl_ce_n)); // R10
endmodule

bind nor_flash_ctrl nor_flash_ctrl_chk #(
  .NDIE(NDIE), .AW(AW), .DW(DW), .CLK_NS(CLK_NS), .T_WP_NS(T_WP_NS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_ready(req_ready), .done(done),
  .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
  .fl_addr(fl_addr), .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe)
);

// File: tb/nor_flash_ctrl_test.sv
module nor_flash_ctrl_test;
  localparam int AW = 19, DW = 16, NDIE = 2;
  localparam int WP_EXP = 3;      // ceil(50/20)
  localparam int RD_EXP = 4;      // max(ceil(100/20)-1, ceil(40/20))
  localparam int DF_EXP = 2;      // ceil(30/20)
  localparam int CE_WR_MIN = 5;   // ceil(100/20)

  logic clk = 1'b0, rst_n = 1'b0;
  always #10 clk = ~clk;

  logic req_valid = 1'b0, req_erase = 1'b0;
  logic [0:0] req_die = '0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic req_ready, done, err, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [NDIE-1:0] fl_ce_n;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_out;
  logic [DW-1:0] fl_dq_in = '0;

  nor_flash_ctrl uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_erase(req_erase), .req_die(req_die), .req_addr(req_addr),
    .req_data(req_data), .done(done), .err(err), .fl_ce_n(fl_ce_n),
    .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_addr(fl_addr),
    .fl_dq_out(fl_dq_out), .fl_dq_oe(fl_dq_oe), .fl_dq_in(fl_dq_in)
  );

  int n_chk = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // behavioural flash model and per-clock reference checks
  logic [AW-1:0] log_a[$];
  logic [DW-1:0] log_d[$];
  int kinds[$];
  int rd_count = 0, cur_die = 0;
  logic [DW-1:0] done_val = '0;
  bit prev_we = 1, prev_oe = 1, prev_ce = 0, wr_in_ce = 0, gap_armed = 0;
  int wlow = 0, olow = 0, celow = 0, gap = 0;
  logic [AW-1:0] a_fall;

  always @(negedge clk) if (rst_n) begin
    logic [DW-1:0] v;
    bit ce_any;
    ce_any = (fl_ce_n != '1);
    chk(fl_ce_n == 2'b11 || fl_ce_n == 2'b10 || fl_ce_n == 2'b01, "R4", "one chip enable", fl_ce_n, 2'b10);
    chk(fl_we_n || fl_oe_n, "R4", "strobes exclusive", {fl_we_n, fl_oe_n}, 2'b11);
    chk(fl_we_n || fl_dq_oe, "R4", "drive while write", fl_dq_oe, 1);
    chk(fl_oe_n || !fl_dq_oe, "R5", "float while read", fl_dq_oe, 0);
    // write strobe
    if (prev_we && !fl_we_n) begin
      a_fall = fl_addr; wlow = 1; wr_in_ce = 1;
      chk(fl_ce_n == ~(2'b01 << cur_die), "R4", "die select on write", fl_ce_n, ~(2'b01 << cur_die));
      if (gap_armed) chk(gap >= DF_EXP, "R5", "float before write", gap, DF_EXP);
      gap_armed = 0;
    end else if (!fl_we_n) wlow++;
    if (!prev_we && fl_we_n) begin
      chk(wlow == WP_EXP, "R3", "write low cycles", wlow, WP_EXP);
      chk(fl_addr == a_fall, "R3", "address held", fl_addr, a_fall);
      log_a.push_back(fl_addr);
      log_d.push_back(fl_dq_out);
    end
    // output enable
    if (prev_oe && !fl_oe_n) begin
      olow = 1; rd_count++;
      chk(fl_ce_n == ~(2'b01 << cur_die), "R4", "die select on read", fl_ce_n, ~(2'b01 << cur_die));
      if (gap_armed) chk(gap >= DF_EXP, "R5", "float before read", gap, DF_EXP);
      gap_armed = 0;
      v = done_val;
      if (kinds.size() > 0) begin
        v[7] = ~done_val[7];
        v[5] = kinds.pop_front() != 0;
        v[6] = rd_count[0];
      end
      fl_dq_in <= v;
    end else if (!fl_oe_n) olow++;
    if (!prev_oe && fl_oe_n) begin
      chk(olow == RD_EXP, "R5", "read low cycles", olow, RD_EXP);
      gap = 1; gap_armed = 1;
    end else if (gap_armed) gap++;
    // chip enable span around writes
    if (ce_any) celow++;
    else begin
      if (prev_ce && wr_in_ce) chk(celow >= CE_WR_MIN, "R3", "write cycle span", celow, CE_WR_MIN);
      celow = 0; wr_in_ce = 0;
    end
    prev_ce = ce_any; prev_we = fl_we_n; prev_oe = fl_oe_n;
  end

  task automatic run(input bit er, input int die, input logic [AW-1:0] a,
                     input logic [DW-1:0] d, input int nk, input logic [7:0] kbits,
                     input bit exp_err, input int exp_reads, input bit noise,
                     input string rtag);
    logic [AW-1:0] ea[$];
    logic [DW-1:0] ed[$];
    int cyc;
    string wtag;
    log_a.delete(); log_d.delete(); kinds.delete();
    for (int i = 0; i < nk; i++) kinds.push_back(int'(kbits[i]));
    rd_count = 0; cur_die = die;
    done_val = er ? '1 : d;
    @(negedge clk);
    chk(req_ready, "R10", "ready when idle", req_ready, 1);
    req_valid = 1; req_erase = er; req_die = 1'(die); req_addr = a; req_data = d;
    @(negedge clk);
    if (noise) begin
      req_erase = ~er; req_die = 1'(~die); req_addr = ~a; req_data = ~d;
    end else req_valid = 0;
    cyc = 0;
    while (!done && cyc < 3000) begin
      chk(!req_ready, "R10", "ready low while busy", req_ready, 0);
      @(negedge clk); cyc++;
    end
    req_valid = 0;
    chk(done, "R10", "done pulse seen", done, 1);
    chk(err == exp_err, exp_err ? "R9" : "R6", "error flag", err, exp_err);
    @(negedge clk);
    chk(!done, "R10", "done one cycle", done, 0);
    chk(req_ready, "R10", "ready after done", req_ready, 1);
    repeat (4) @(negedge clk);
    ea = {AW'(12'h555), AW'(12'h2AA), AW'(12'h555)};
    ed = {DW'(8'hAA), DW'(8'h55), DW'(er ? 8'h80 : 8'hA0)};
    if (er) begin
      ea.push_back(AW'(12'h555)); ed.push_back(DW'(8'hAA));
      ea.push_back(AW'(12'h2AA)); ed.push_back(DW'(8'h55));
      ea.push_back(a); ed.push_back(DW'(8'h30));
    end else begin
      ea.push_back(a); ed.push_back(d);
    end
    if (exp_err) begin ea.push_back(a); ed.push_back(DW'(8'hF0)); end
    wtag = er ? "R2" : "R1";
    chk(log_a.size() == ea.size(), exp_err ? "R9" : wtag, "write count", log_a.size(), ea.size());
    for (int i = 0; i < ea.size() && i < log_a.size(); i++) begin
      chk(log_a[i] == ea[i], (exp_err && i == ea.size()-1) ? "R9" : wtag, "write address", log_a[i], ea[i]);
      chk(log_d[i] == ed[i], (exp_err && i == ea.size()-1) ? "R9" : wtag, "write data", log_d[i], ed[i]);
    end
    chk(rd_count == exp_reads, rtag, "status reads", rd_count, exp_reads);
  endtask

  initial begin
    #(4_000_000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(fl_ce_n == 2'b11, "R11", "reset ce", fl_ce_n, 2'b11);
    chk(fl_we_n && fl_oe_n, "R11", "reset strobes", {fl_we_n, fl_oe_n}, 2'b11);
    chk(!fl_dq_oe, "R11", "reset drive", fl_dq_oe, 0);
    chk(!done && req_ready, "R11", "reset handshake", {done, req_ready}, 2'b01);
    rst_n = 1;
    // word write, two plain busy reads then match (R1 R6 R7)
    run(0, 0, 19'h12345, 16'hA5C3, 2, 8'h00, 0, 3, 0, "R7");
    // word write with bit 7 low, immediate match on die 1 (R1 R6)
    run(0, 1, 19'h7FFFF, 16'h0042, 0, 8'h00, 0, 1, 0, "R6");
    // sector erase, three busy reads (R2 R7)
    run(1, 0, 19'h7C000, 16'h0000, 3, 8'h00, 0, 4, 0, "R7");
    // timeout flag once, re-read matches; done word has bit 5 high (R8)
    run(0, 1, 19'h00400, 16'h00A0, 1, 8'h01, 0, 2, 0, "R8");
    // timeout flag then mismatch -> abort (R9)
    run(0, 0, 19'h3ABCD, 16'h1234, 2, 8'h01, 1, 2, 0, "R9");
    // erase, timeout flag twice -> abort (R9)
    run(1, 1, 19'h10000, 16'h0000, 2, 8'h03, 1, 2, 0, "R9");
    // request inputs held active while busy are ignored (R10 R7)
    run(0, 0, 19'h55555, 16'hFFFF, 4, 8'h00, 0, 5, 1, "R7");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule